// File: doc/BRIEF.md
# Parity Error Address Capture

This block sits beside a small RAM that holds conversion results. Each RAM word carries one stored parity bit. On every read that the RAM marks valid, the block checks the word's parity again. The first time a word fails the check, the block records that word's index and raises a sticky flag. The recorded index then stays locked, and later parity failures are ignored, until software reads the block's status register through a small synchronous read port.

A normal register read returns the recorded address and re-arms the block for the next failure. While the debug-mode input is high, a read still returns the address, but the lock stays in place. This lets a debugger inspect the register without losing the record that software has not yet collected. The address appears in the register as a 32-bit-aligned byte address. A single-cycle pipeline sits between the parity check and the capture register, and the design keeps the timing of the two in step so that no failure is dropped when a capture and a release fall close together.

Top module: `parity_err_capture`

## Requirements
- R1: A word is in error only when `ram_rd_vld` is high and the XOR of all bits of `ram_rd_data` together with `ram_rd_par` equals 1, which is the even parity rule. A mismatch while `ram_rd_vld` is low, or a word with correct parity, is never recorded.
- R2: When no capture is held, an errored read sampled at clock edge t sets `err_valid` at edge t+1. The recorded address is that read's `ram_rd_idx`.
- R3: While `err_valid` is high and no releasing read occurs, later errored reads change neither `err_valid` nor the recorded address.
- R4: A register read is a cycle with both `reg_sel` and `reg_rd` high. A register read with `dbg_mode` low is a release: it clears `err_valid` and re-arms the capture. A strobe on `reg_rd` while `reg_sel` is low has no effect.
- R5: A register read with `dbg_mode` high returns the address but leaves `err_valid` and the recorded address unchanged.
- R6: `reg_rdata` places the recorded index in bits [ADDR_LSB+ADDR_W-1:ADDR_LSB], which is bits [11:2] by default. All other bits always read as zero.
- R7: Reset is synchronous and active-high. After reset, `err_valid` is 0 and `reg_rdata` is 0, and the value of the address field is undefined. `reg_rdata` updates at the clock edge that samples a register read and holds its value between reads.
- R8: If an error reaches the capture stage at the same edge as a release, the read returns the old address. The new address is recorded at that edge and `err_valid` stays high, so no error is lost.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ram_rd_vld | input | 1 | RAM read data valid this cycle |
| ram_rd_idx | input | ADDR_W | Word index of the RAM read |
| ram_rd_data | input | DATA_W | Word read from the RAM |
| ram_rd_par | input | 1 | Stored parity bit of the word |
| dbg_mode | input | 1 | Debug mode: register reads do not release the capture |
| reg_sel | input | 1 | Register select |
| reg_rd | input | 1 | Register read strobe |
| reg_rdata | output | REG_W | Register read data, valid the cycle after the strobe |
| err_valid | output | 1 | Sticky flag: an error address is held |

## Verification
The bench uses the defaults: 32-bit words, a 10-bit index, and the field placed at bit 2. With these settings an index of 0x3FF drives bit 11 of the register, and an index of 0x001 drives bit 2, so both ends of the field are covered. Stimulus is timed so that a release lands on the same edge as a captured error in one case, and on the edge before it in another. This exercises the one-cycle check pipeline against the release logic at both offsets. Debug reads are mixed in with pending captures, and register strobes are issued with the select line low.

// File: rtl/pecap_pkg.sv
package pecap_pkg;
  localparam int unsigned REG_W    = 32;
  localparam int unsigned ADDR_LSB = 2;

  typedef struct packed {
    logic hit;
    logic rel;
  } rd_cmd_t;
endpackage

// File: rtl/pecap_parity_chk.sv
module pecap_parity_chk #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 10,
  parameter int unsigned LANE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_vld,
  input  logic [ADDR_W-1:0] rd_idx,
  input  logic [DATA_W-1:0] rd_data,
  input  logic              rd_par,
  output logic              err_vld,
  output logic [ADDR_W-1:0] err_idx
);
  localparam int unsigned LANES = (DATA_W + LANE_W - 1) / LANE_W;
  localparam int unsigned PAD_W = LANES * LANE_W;

  logic [PAD_W-1:0] padded;
  logic [LANES-1:0] lane_par;
  logic             mismatch;

  always_comb begin
    padded = '0;
    padded[DATA_W-1:0] = rd_data;
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign lane_par[g] = ^padded[g*LANE_W +: LANE_W];
  end

  assign mismatch = (^lane_par) ^ rd_par;

  always_ff @(posedge clk) begin
    if (rst) begin
      err_vld <= 1'b0;
    end else begin
      err_vld <= rd_vld & mismatch;
    end
    err_idx <= rd_idx;
  end
endmodule

// File: rtl/pecap_capture.sv
module pecap_capture #(
  parameter int unsigned ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              err_vld,
  input  logic [ADDR_W-1:0] err_idx,
  input  logic              release_i,
  output logic              held,
  output logic [ADDR_W-1:0] held_addr
);
  logic take;

  assign take = err_vld & (~held | release_i);

  always_ff @(posedge clk) begin
    if (rst) begin
      held <= 1'b0;
    end else if (take) begin
      held <= 1'b1;
    end else if (release_i) begin
      held <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (take) begin
      held_addr <= err_idx;
    end
  end
endmodule

// File: rtl/pecap_reg_view.sv
module pecap_reg_view
  import pecap_pkg::*;
#(
  parameter int unsigned ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sel,
  input  logic              rd,
  input  logic              dbg,
  input  logic [ADDR_W-1:0] addr,
  output rd_cmd_t           cmd,
  output logic [REG_W-1:0]  rdata
);
  logic [REG_W-1:0] field;

  always_comb begin
    field = '0;
    field[ADDR_LSB +: ADDR_W] = addr;
  end

  always_comb begin
    cmd.hit = sel & rd;
    cmd.rel = sel & rd & ~dbg;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
    end else if (cmd.hit) begin
      rdata <= field;
    end
  end
endmodule

// File: rtl/parity_err_capture.sv
module parity_err_capture
  import pecap_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ram_rd_vld,
  input  logic [ADDR_W-1:0] ram_rd_idx,
  input  logic [DATA_W-1:0] ram_rd_data,
  input  logic              ram_rd_par,
  input  logic              dbg_mode,
  input  logic              reg_sel,
  input  logic              reg_rd,
  output logic [REG_W-1:0]  reg_rdata,
  output logic              err_valid
);
  logic              chk_err;
  logic [ADDR_W-1:0] chk_idx;
  logic [ADDR_W-1:0] cap_addr;
  rd_cmd_t           cmd;

  pecap_parity_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
    .clk(clk), .rst(rst), .rd_vld(ram_rd_vld), .rd_idx(ram_rd_idx),
    .rd_data(ram_rd_data), .rd_par(ram_rd_par),
    .err_vld(chk_err), .err_idx(chk_idx)
  );

  pecap_capture #(.ADDR_W(ADDR_W)) u_cap (
    .clk(clk), .rst(rst), .err_vld(chk_err), .err_idx(chk_idx),
    .release_i(cmd.rel), .held(err_valid), .held_addr(cap_addr)
  );

  pecap_reg_view #(.ADDR_W(ADDR_W)) u_view (
    .clk(clk), .rst(rst), .sel(reg_sel), .rd(reg_rd), .dbg(dbg_mode),
    .addr(cap_addr), .cmd(cmd), .rdata(reg_rdata)
  );
endmodule

// File: rtl/pecap_checker.sv
module pecap_checker
  import pecap_pkg::*;
#(
  parameter int unsigned ADDR_W = 10
) (
  input logic              clk,
  input logic              rst,
  input logic              reg_sel,
  input logic              reg_rd,
  input logic              dbg_mode,
  input logic [REG_W-1:0]  reg_rdata,
  input logic              err_valid,
  input logic [ADDR_W-1:0] cap_addr,
  input logic              chk_err
);
  localparam logic [REG_W-1:0] FMASK = ((REG_W)'(1) << ADDR_W) - 1;
  localparam logic [REG_W-1:0] RMASK = ~(FMASK << ADDR_LSB);

  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (rst)
    (reg_rdata & RMASK) == '0); // R6
  AST_RDATA_ECHO: assert property (@(posedge clk) disable iff (rst)
    (reg_sel && reg_rd) |=> reg_rdata[ADDR_LSB +: ADDR_W] == $past(cap_addr)); // R6
  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (rst)
    !(reg_sel && reg_rd) |=> $stable(reg_rdata)); // R7
  AST_FIRST_HELD: assert property (@(posedge clk) disable iff (rst)
    (err_valid && !(reg_sel && reg_rd && !dbg_mode)) |=> err_valid && $stable(cap_addr)); // R3
  AST_RELEASE_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (reg_sel && reg_rd && !dbg_mode && !chk_err) |=> !err_valid); // R4
  AST_DBG_KEEP: assert property (@(posedge clk) disable iff (rst)
    (reg_sel && reg_rd && dbg_mode && err_valid) |=> err_valid && $stable(cap_addr)); // R5
  AST_NO_LOSS: assert property (@(posedge clk) disable iff (rst)
    chk_err |=> err_valid); // R8
endmodule

bind parity_err_capture pecap_checker #(.ADDR_W(ADDR_W)) u_pecap_checker (
  .clk(clk), .rst(rst), .reg_sel(reg_sel), .reg_rd(reg_rd), .dbg_mode(dbg_mode),
  .reg_rdata(reg_rdata), .err_valid(err_valid), .cap_addr(cap_addr), .chk_err(chk_err)
);

// File: tb/parity_err_capture_tb_top.sv
module parity_err_capture_tb_top;
  localparam int DW = 32;
  localparam int AW = 10;
  localparam int RW = 32;
  localparam int LSB = 2;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          ram_rd_vld = 1'b0;
  logic [AW-1:0] ram_rd_idx = '0;
  logic [DW-1:0] ram_rd_data = '0;
  logic          ram_rd_par = 1'b0;
  logic          dbg_mode = 1'b0;
  logic          reg_sel = 1'b0;
  logic          reg_rd = 1'b0;
  logic [RW-1:0] reg_rdata;
  logic          err_valid;

  always #10 clk = ~clk;

  parity_err_capture #(.DATA_W(DW), .ADDR_W(AW)) dut_i (
    .clk(clk), .rst(rst), .ram_rd_vld(ram_rd_vld), .ram_rd_idx(ram_rd_idx),
    .ram_rd_data(ram_rd_data), .ram_rd_par(ram_rd_par), .dbg_mode(dbg_mode),
    .reg_sel(reg_sel), .reg_rd(reg_rd), .reg_rdata(reg_rdata), .err_valid(err_valid)
  );

  int    vectors = 0;
  int    miscompares = 0;
  string phase = "R7 reset";
  bit    started = 0;
  bit    done = 0;

  bit            m_valid = 0, m_pend = 0, m_known = 0, m_rknown = 1;
  logic [AW-1:0] m_addr = '0, m_pidx = '0;
  logic [RW-1:0] m_rdata = '0;

  always @(posedge clk) begin
    bit rd, rel;
    started = 1;
    if (rst) begin
      m_valid = 0; m_rdata = '0; m_rknown = 1;
    end else begin
      rd  = reg_sel && reg_rd;
      rel = rd && !dbg_mode;
      if (rd) begin
        m_rdata  = RW'(m_addr) << LSB;
        m_rknown = m_known;
      end
      if (m_pend && (!m_valid || rel)) begin
        m_valid = 1; m_addr = m_pidx; m_known = 1;
      end else if (rel) begin
        m_valid = 0;
      end
    end
    m_pend = !rst && ram_rd_vld && (^{ram_rd_data, ram_rd_par});
    m_pidx = ram_rd_idx;
  end

  always @(negedge clk) begin
    logic [RW-1:0] mask;
    if (started && !done) begin
      vectors++;
      if (err_valid !== m_valid) begin
        miscompares++;
        $display("FAIL %s err_valid act=%0b exp=%0b", phase, err_valid, m_valid);
      end
      mask = m_rknown ? '1 : ~(((RW'(1) << AW) - 1) << LSB);
      if ((reg_rdata & mask) !== (m_rdata & mask)) begin
        miscompares++;
        $display("FAIL %s reg_rdata act=%h exp=%h", phase, reg_rdata & mask, m_rdata & mask);
      end
    end
  end

  task automatic step(input bit vld, input logic [AW-1:0] idx, input logic [DW-1:0] data,
                      input bit bad, input bit sel, input bit rd, input bit dbg);
    @(negedge clk);
    #1;
    ram_rd_vld = vld; ram_rd_idx = idx; ram_rd_data = data;
    ram_rd_par = (^data) ^ bad;
    reg_sel = sel; reg_rd = rd; dbg_mode = dbg;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(0, '0, '0, 0, 0, 0, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog expired act=running exp=finished");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    idle(3);
    @(negedge clk); #1 rst = 1'b0;
    idle(2);
    phase = "R1 good parity";
    step(1, 10'h011, 32'hDEAD_BEEF, 0, 0, 0, 0);
    step(1, 10'h012, 32'h0000_0000, 0, 0, 0, 0);
    step(1, 10'h013, 32'hFFFF_FFFF, 0, 0, 0, 0);
    phase = "R1 bad parity without valid";
    step(0, 10'h014, 32'h1234_5678, 1, 0, 0, 0);
    idle(3);
    phase = "R2 first capture";
    step(1, 10'h155, 32'hA5A5_0001, 1, 0, 0, 0);
    idle(3);
    phase = "R3 later errors ignored";
    step(1, 10'h2AA, 32'h0F0F_F0F0, 1, 0, 0, 0);
    step(1, 10'h3FF, 32'h8000_0000, 1, 0, 0, 0);
    idle(2);
    phase = "R5 debug read keeps hold";
    step(0, '0, '0, 0, 1, 1, 1);
    idle(2);
    step(1, 10'h0F0, 32'h7, 1, 1, 1, 1);
    idle(3);
    phase = "R4 strobe without select";
    step(0, '0, '0, 0, 0, 1, 0);
    idle(2);
    phase = "R4 release read";
    step(0, '0, '0, 0, 1, 1, 0);
    idle(2);
    step(0, '0, '0, 0, 1, 1, 0);
    idle(2);
    phase = "R4 re-armed capture low index";
    step(1, 10'h001, 32'h0000_0003, 1, 0, 0, 0);
    idle(3);
    phase = "R8 release meets captured error";
    step(1, 10'h200, 32'h5555_5555, 1, 0, 0, 0);
    step(0, '0, '0, 0, 1, 1, 0);
    idle(2);
    step(0, '0, '0, 0, 1, 1, 0);
    idle(2);
    phase = "R8 release same cycle as faulty read";
    step(1, 10'h3FF, 32'h0000_0001, 1, 1, 1, 0);
    idle(3);
    phase = "R6 top index field";
    step(0, '0, '0, 0, 1, 1, 1);
    idle(2);
    step(0, '0, '0, 0, 1, 1, 0);
    idle(3);
    phase = "R7 reset mid-capture";
    step(1, 10'h0AA, 32'h1, 1, 0, 0, 0);
    idle(2);
    @(negedge clk); #1 rst = 1'b1;
    idle(2);
    @(negedge clk); #1 rst = 1'b0;
    idle(3);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule